// File: doc/BRIEF.md
# Multi-Line Tagged Receive Queue

This block is the shared receive queue of an eight-line asynchronous serial multiplexer. Every line receiver offers characters to one common first-in first-out store. Each character carries its line number and its error flags. A modem watcher uses the same store to report changes of the carrier-detect level. Only one request can be written per clock. A fixed-priority arbiter picks the winner, and a requester that loses keeps its request raised until its grant arrives.

The host works through a small register port with two registers. The control/status register holds the receive interrupt enable and the master reset trigger, and it reports data-available, reset-in-progress and diagnostic failure. Each read of the receive-buffer register removes one tagged word. A master reset, started by the reset pin or by software, clears the queue. When the reset finishes, the block places eight self-test status bytes in the queue.

Top module: `mux_rx_silo`

## Requirements
- R1: A receive-buffer read (reg_sel=1) returns the oldest entry on reg_rdata in the cycle after the read, with bit 15 set, and removes that entry. When the queue is empty the word is 0x0000 and nothing is removed.
- R2: A data entry holds the character in bits 7:0, the line number in bits 11:8, the framing-error (break) flag in bit 13 and the parity-error flag in bit 12.
- R3: A modem-change entry has bits 14:12 all set, the reporting line number in bits 11:8, the carrier-detect level in bit 4, and bits 7:5 and 3:0 clear.
- R4: At most one request is granted per cycle. The grant goes to the lowest-numbered requesting line, and the modem request ranks below every line. Each grant output is high in the same cycle as the request it accepts.
- R5: Entries are read back in the order in which they were granted.
- R6: The queue holds 64 entries. A request granted while the queue is full is dropped. Bit 14 (overrun) is then set on the next accepted data entry. Modem entries neither carry nor clear this pending flag.
- R7: A data entry that would have overrun, framing and parity all set is written with the parity bit cleared, so that it never reads as a modem entry.
- R8: A control/status read returns bit 7 = queue non-empty, bit 6 = interrupt enable, bit 5 = master reset in progress and bit 13 = diagnostic failure. All other bits read 0. A write loads bit 6 into the interrupt enable.
- R9: rx_irq is high exactly while the interrupt enable is set and the queue is non-empty. It changes at the same clock edge as the state that causes the change.
- R10: The rst pin, or a control/status write with bit 5 set, starts a master reset. The reset empties the queue, clears the interrupt enable and the pending overrun, and blocks all grants. Bit 5 reads 1 until the status bytes have been loaded.
- R11: A master reset ends by writing exactly eight status entries on line 0 with no error flags. The first is the self-test code: octal 200 if selftest_fail is set, otherwise octal 203 if selftest_skip is set, otherwise octal 201. The next seven are version codes (VER_BASE + k) mod 128 for k = 1..7. Bit 13 of the control/status register reads 1 after a failed self-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a master reset |
| line_req | input | 8 | Per-line push request, held until granted |
| line_char | input | 64 | Per-line character, line i in bits 8i+7:8i |
| line_ferr | input | 8 | Per-line framing error (break) flag |
| line_perr | input | 8 | Per-line parity error flag |
| line_grant | output | 8 | Per-line grant, one-hot or zero |
| mdm_req | input | 1 | Modem-change push request, held until granted |
| mdm_line | input | 4 | Line whose carrier changed |
| mdm_dcd | input | 1 | Present carrier-detect level |
| mdm_grant | output | 1 | Grant for the modem request |
| selftest_fail | input | 1 | Self-test failed, sampled at the start of the status load |
| selftest_skip | input | 1 | Self-test skipped, sampled at the start of the status load |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = control/status, 1 = receive buffer |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the previous read, held until the next read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A grant appears in the same cycle as its request, and the entry is written at the closing edge of that cycle. Read data and the updated rx_irq are both due one edge after the read or the push. The bench changes inputs on the falling edge, samples the grants shortly after that falling edge, and samples reg_rdata and rx_irq on the next falling edge, after the single register stage. The master reset length is not counted exactly. The bench polls bit 5 until it clears and only then checks the status bytes, the diagnostic bit and the empty-queue reads.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int ENTRY_W = 15;

  localparam logic [7:0] ST_PASS = 8'o201;
  localparam logic [7:0] ST_SKIP = 8'o203;
  localparam logic [7:0] ST_FAIL = 8'o200;

  typedef struct packed {
    logic       ovr;
    logic       frm;
    logic       par;
    logic [3:0] line;
    logic [7:0] ch;
  } entry_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_LOAD} seq_state_t;

  typedef enum logic [1:0] {RD_NONE, RD_CSR, RD_EMPTY, RD_DATA} rd_kind_t;

  // Data entry; parity is dropped when all three flags would be set.
  function automatic entry_t make_data(input logic ovr, input logic frm,
                                       input logic par, input logic [3:0] line,
                                       input logic [7:0] ch);
    entry_t e;
    e.ovr  = ovr;
    e.frm  = frm;
    e.par  = par & ~(ovr & frm);
    e.line = line;
    e.ch   = ch;
    return e;
  endfunction

  function automatic entry_t make_modem(input logic [3:0] line, input logic dcd);
    entry_t e;
    e.ovr  = 1'b1;
    e.frm  = 1'b1;
    e.par  = 1'b1;
    e.line = line;
    e.ch   = {3'b000, dcd, 4'b0000};
    return e;
  endfunction

endpackage

// File: rtl/rxs_arbiter.sv
module rxs_arbiter #(
  parameter int N_REQ = 9
) (
  input  logic [N_REQ-1:0] req,
  input  logic             en,
  output logic [N_REQ-1:0] gnt,
  output logic             any
);
  localparam logic [N_REQ-1:0] ONE = {{(N_REQ-1){1'b0}}, 1'b1};

  logic [N_REQ-1:0] lowest;

  // Isolate the lowest set bit: lowest index has priority.
  assign lowest = req & ((~req) + ONE);
  assign gnt    = en ? lowest : '0;
  assign any    = en & (|req);
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 15,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic [AW:0]  count,
  output logic [AW:0]  count_nxt,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [W-1:0]  rd_q;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = rd_q;

  always_comb begin
    if (rst || flush) count_nxt = '0;
    else              count_nxt = count + (AW+1)'(wr_en) - (AW+1)'(rd_en);
  end

  // Storage without reset and with a registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
    end
    count <= count_nxt;
  end
endmodule

// File: rtl/rxs_reset_seq.sv
module rxs_reset_seq
  import rxs_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int N_STATUS   = 8,
  parameter int VER_BASE   = 33,
  localparam int CW        = $clog2(RST_CYCLES),
  localparam int SW        = $clog2(N_STATUS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       st_fail,
  input  logic       st_skip,
  output logic       busy,
  output logic       flush,
  output logic       load_valid,
  output logic [7:0] load_byte,
  output logic       diag_fail
);
  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] idx;
  logic          fail_q, skip_q;
  logic [7:0]    code, ver;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state     <= SEQ_WAIT;
      cnt       <= '0;
      idx       <= '0;
      fail_q    <= 1'b0;
      skip_q    <= 1'b0;
      diag_fail <= 1'b0;
    end else begin
      case (state)
        SEQ_WAIT: begin
          if (cnt == CW'(RST_CYCLES-1)) begin
            state     <= SEQ_LOAD;
            idx       <= '0;
            fail_q    <= st_fail;
            skip_q    <= st_skip;
            diag_fail <= st_fail;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_LOAD: begin
          if (idx == SW'(N_STATUS-1)) state <= SEQ_IDLE;
          else                        idx   <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (fail_q)      code = ST_FAIL;
    else if (skip_q) code = ST_SKIP;
    else             code = ST_PASS;
    ver = 8'(VER_BASE + int'(idx)) & 8'h7F;
  end

  assign busy       = (state != SEQ_IDLE);
  assign flush      = (state == SEQ_WAIT);
  assign load_valid = (state == SEQ_LOAD);
  assign load_byte  = (idx == '0) ? code : ver;
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import rxs_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int DEPTH      = 64,
  parameter int RST_CYCLES = 16,
  parameter int N_STATUS   = 8,
  parameter int VER_BASE   = 33
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LINES-1:0]   line_req,
  input  logic [N_LINES*8-1:0] line_char,
  input  logic [N_LINES-1:0]   line_ferr,
  input  logic [N_LINES-1:0]   line_perr,
  output logic [N_LINES-1:0]   line_grant,
  input  logic                 mdm_req,
  input  logic [3:0]           mdm_line,
  input  logic                 mdm_dcd,
  output logic                 mdm_grant,
  input  logic                 selftest_fail,
  input  logic                 selftest_skip,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_sel,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 rx_irq
);
  localparam int N_REQ = N_LINES + 1;
  localparam int AW    = $clog2(DEPTH);

  // Master reset sequencer
  logic       seq_start, seq_busy, seq_flush, seq_load, diag_fail;
  logic [7:0] seq_byte;

  assign seq_start = reg_wr && !reg_sel && reg_wdata[5];

  rxs_reset_seq #(
    .RST_CYCLES(RST_CYCLES), .N_STATUS(N_STATUS), .VER_BASE(VER_BASE)
  ) u_seq (
    .clk(clk), .rst(rst), .start(seq_start),
    .st_fail(selftest_fail), .st_skip(selftest_skip),
    .busy(seq_busy), .flush(seq_flush), .load_valid(seq_load),
    .load_byte(seq_byte), .diag_fail(diag_fail)
  );

  // Candidate entries, one per requester
  logic   ovr_q, ovr_d;
  entry_t cand [N_REQ];

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    assign cand[gi] = make_data(ovr_q, line_ferr[gi], line_perr[gi],
                                4'(gi), line_char[gi*8 +: 8]);
  end
  assign cand[N_LINES] = make_modem(mdm_line, mdm_dcd);

  // Arbitration
  logic [N_REQ-1:0] gnt;
  logic             any_req;

  rxs_arbiter #(.N_REQ(N_REQ)) u_arb (
    .req({mdm_req, line_req}), .en(!seq_busy), .gnt(gnt), .any(any_req)
  );

  assign line_grant = gnt[N_LINES-1:0];
  assign mdm_grant  = gnt[N_LINES];

  entry_t win;
  logic   win_is_data;

  always_comb begin
    win = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) win = cand[i];
    end
  end
  assign win_is_data = |gnt[N_LINES-1:0];

  // Queue storage
  logic                 fifo_wr, fifo_rd, fifo_full, fifo_empty;
  logic [ENTRY_W-1:0]   fifo_wdata, fifo_rdata;
  logic [AW:0]          fifo_cnt, fifo_cnt_nxt;
  logic                 push_ok, push_drop, rd_rbuf;
  entry_t               st_entry;

  assign push_ok   = any_req && !fifo_full;
  assign push_drop = any_req && fifo_full;
  assign rd_rbuf   = reg_rd && reg_sel;
  assign fifo_rd   = rd_rbuf && !fifo_empty;

  always_comb begin
    st_entry      = '0;
    st_entry.ch   = seq_byte;
    fifo_wr       = seq_load ? 1'b1 : push_ok;
    fifo_wdata    = seq_load ? st_entry : win;
  end

  rxs_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(seq_flush),
    .wr_en(fifo_wr), .wr_data(fifo_wdata), .rd_en(fifo_rd),
    .rd_data(fifo_rdata), .count(fifo_cnt), .count_nxt(fifo_cnt_nxt),
    .full(fifo_full), .empty(fifo_empty)
  );

  // Control state
  logic     ie_q, ie_d, irq_q;
  rd_kind_t rd_kind_q;
  logic [15:0] csr_word, csr_q;
  logic        wdata_unused;

  assign wdata_unused = ^{reg_wdata[15:7], reg_wdata[4:0]};

  always_comb begin
    if (seq_start)               ie_d = 1'b0;
    else if (reg_wr && !reg_sel) ie_d = reg_wdata[6];
    else                         ie_d = ie_q;

    if (seq_start)                     ovr_d = 1'b0;
    else if (push_drop)                ovr_d = 1'b1;
    else if (push_ok && win_is_data)   ovr_d = 1'b0;
    else                               ovr_d = ovr_q;

    csr_word     = '0;
    csr_word[13] = diag_fail;
    csr_word[7]  = !fifo_empty;
    csr_word[6]  = ie_q;
    csr_word[5]  = seq_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      irq_q     <= 1'b0;
      ovr_q     <= 1'b0;
      rd_kind_q <= RD_NONE;
      csr_q     <= '0;
    end else begin
      ie_q  <= ie_d;
      irq_q <= ie_d && (fifo_cnt_nxt != '0);
      ovr_q <= ovr_d;
      if (reg_rd) begin
        if (!reg_sel) begin
          rd_kind_q <= RD_CSR;
          csr_q     <= csr_word;
        end else if (fifo_empty) begin
          rd_kind_q <= RD_EMPTY;
        end else begin
          rd_kind_q <= RD_DATA;
        end
      end
    end
  end

  always_comb begin
    case (rd_kind_q)
      RD_CSR:  reg_rdata = csr_q;
      RD_DATA: reg_rdata = {1'b1, fifo_rdata};
      default: reg_rdata = '0;
    endcase
  end

  assign rx_irq = irq_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int N_LINES = 8,
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] line_grant,
  input logic               mdm_grant,
  input logic               seq_busy,
  input logic [AW:0]        fifo_count,
  input logic               ie,
  input logic               rx_irq,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [15:0]        reg_wdata,
  input logic [15:0]        reg_rdata
);
  // R4: never more than one grant in a cycle
  a_r4_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mdm_grant, line_grant}));

  // R10: no grants while a master reset runs
  a_r10_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    seq_busy |-> ({mdm_grant, line_grant} == '0));

  // R10: a reset write makes the sequencer busy at the next edge
  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_wdata[5]) |=> seq_busy);

  // R6: occupancy never passes the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= (AW+1)'(DEPTH));

  // R9: interrupt tracks enable and occupancy
  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    rx_irq == (ie && (fifo_count != '0)));

  // R1: an empty read returns zero, a non-empty read sets the valid bit
  a_r1_empty_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel && fifo_count == '0) |=> (reg_rdata == 16'h0000));
  a_r1_valid_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel && fifo_count != '0) |=> reg_rdata[15]);

  // R3: a word marked as modem change has only the carrier bit in its low byte
  a_r3_modem_shape: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel && fifo_count != '0) |=>
      (reg_rdata[14:12] != 3'b111 || (reg_rdata[7:5] == 3'b000 && reg_rdata[3:0] == 4'h0)));
endmodule

bind mux_rx_silo rxs_checker #(.N_LINES(N_LINES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .line_grant(line_grant), .mdm_grant(mdm_grant),
  .seq_busy(seq_busy), .fifo_count(fifo_cnt), .ie(ie_q), .rx_irq(rx_irq),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/mux_rx_silo_test.sv
`timescale 1ns/1ps
module mux_rx_silo_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  line_req = '0;
  logic [63:0] line_char = '0;
  logic [7:0]  line_ferr = '0, line_perr = '0;
  logic [7:0]  line_grant;
  logic        mdm_req = 1'b0;
  logic [3:0]  mdm_line = '0;
  logic        mdm_dcd = 1'b0;
  logic        mdm_grant;
  logic        selftest_fail = 1'b0, selftest_skip = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rx_irq;

  mux_rx_silo uut (
    .clk(clk), .rst(rst), .line_req(line_req), .line_char(line_char),
    .line_ferr(line_ferr), .line_perr(line_perr), .line_grant(line_grant),
    .mdm_req(mdm_req), .mdm_line(mdm_line), .mdm_dcd(mdm_dcd), .mdm_grant(mdm_grant),
    .selftest_fail(selftest_fail), .selftest_skip(selftest_skip),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int q[$];
  bit ovr_p = 0;
  bit ie_m  = 0;
  logic [7:0] lch [8];
  bit lfe [8];
  bit lpe [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_data(int ln, int ch, bit fe, bit pe, bit ov);
    return (int'(ov) << 14) | (int'(fe) << 13) | (int'(pe && !(ov && fe)) << 12)
           | (ln << 8) | ch;
  endfunction

  function automatic void accept_data(int i);
    if (q.size() >= 64) ovr_p = 1;
    else begin
      q.push_back(exp_data(i, int'(lch[i]), lfe[i], lpe[i], ovr_p));
      ovr_p = 0;
    end
  endfunction

  function automatic void accept_modem();
    if (q.size() >= 64) ovr_p = 1;
    else q.push_back(32'h7000 | (int'(mdm_line) << 8) | (int'(mdm_dcd) << 4));
  endfunction

  task automatic reg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic reg_read(input bit sel, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_sel = sel;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic irq_check(input string r);
    bit e = ie_m && (q.size() > 0);
    check(rx_irq == e, r, int'(rx_irq), int'(e));
  endtask

  task automatic read_check(input string r);
    logic [15:0] d;
    int e;
    reg_read(1, d);
    e = (q.size() > 0) ? (32'h8000 | q.pop_front()) : 0;
    check(int'(d) == e, r, int'(d), e);
    irq_check("R9 irq after read");
  endtask

  task automatic drain(input string r);
    while (q.size() > 0) read_check(r);
    read_check("R1 empty read");
  endtask

  // Raise requests in mask (plus modem) and hold each until granted.
  task automatic push_set(input logic [7:0] mask, input bit mreq);
    logic [7:0] pend = mask;
    bit mp = mreq;
    while (pend != 0 || mp) begin
      logic [8:0] rv, ev;
      @(negedge clk);
      line_req = pend; mdm_req = mp;
      for (int i = 0; i < 8; i++) begin
        line_char[i*8 +: 8] = lch[i];
        line_ferr[i] = lfe[i];
        line_perr[i] = lpe[i];
      end
      #1;
      rv = {mp, pend};
      ev = rv & (~rv + 9'd1);
      check({mdm_grant, line_grant} == ev, "R4 priority grant",
            int'({mdm_grant, line_grant}), int'(ev));
      for (int i = 0; i < 8; i++) begin
        if (line_grant[i]) begin accept_data(i); pend[i] = 0; end
      end
      if (mdm_grant) begin accept_modem(); mp = 0; end
    end
    @(negedge clk);
    line_req = '0; mdm_req = 0;
    irq_check("R9 irq after push");
  endtask

  task automatic push_one(input int ln, input logic [7:0] ch, input bit fe, input bit pe);
    lch[ln] = ch; lfe[ln] = fe; lpe[ln] = pe;
    push_set(8'(1 << ln), 0);
  endtask

  task automatic push_modem(input logic [3:0] ln, input bit dcd);
    mdm_line = ln; mdm_dcd = dcd;
    push_set(8'h00, 1);
  endtask

  task automatic post_reset(input bit fail, input bit skip);
    logic [15:0] d;
    int code;
    for (int k = 0; k < 200; k++) begin
      reg_read(0, d);
      if (!d[5]) break;
    end
    reg_read(0, d);
    check(d == (fail ? 16'h2080 : 16'h0080), "R8 R11 csr after reset", int'(d),
          fail ? 32'h2080 : 32'h0080);
    code = fail ? 8'o200 : (skip ? 8'o203 : 8'o201);
    q.push_back(code);
    for (int k = 1; k < 8; k++) q.push_back((33 + k) & 8'h7F);
    drain("R11 status bytes");
  endtask

  task automatic master_reset(input bit fail, input bit skip);
    logic [15:0] d;
    selftest_fail = fail; selftest_skip = skip;
    reg_write(0, 16'h0060);
    q.delete(); ovr_p = 0; ie_m = 0;
    reg_read(0, d);
    check((d & 16'h0060) == 16'h0020, "R10 busy and ie cleared", int'(d), 32'h0020);
    @(negedge clk);
    line_req = 8'h01; lch[0] = 8'h11;
    #1;
    check(line_grant == 8'h00, "R10 no grant while busy", int'(line_grant), 0);
    @(negedge clk);
    line_req = '0;
    post_reset(fail, skip);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin lch[i] = '0; lfe[i] = 0; lpe[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(rx_irq == 0, "R9 irq at reset", int'(rx_irq), 0);
    reg_read(0, d);
    check(d == 16'h0020, "R10 csr during reset", int'(d), 32'h0020);
    post_reset(0, 0);

    reg_write(0, 16'h0040); ie_m = 1;
    reg_read(0, d);
    check(d == 16'h0040, "R8 csr ie set empty", int'(d), 32'h0040);

    // R2 plain and flagged data
    push_one(3, 8'h5A, 0, 0);
    reg_read(0, d);
    check(d == 16'h00C0, "R8 csr avail", int'(d), 32'h00C0);
    push_one(5, 8'hC3, 1, 1);
    push_one(7, 8'h00, 1, 0);
    drain("R2 data entry");

    // R3 modem entries
    push_modem(4'd6, 1);
    push_modem(4'd2, 0);
    drain("R3 modem entry");

    // R4/R5 all lines together plus modem
    for (int i = 0; i < 8; i++) begin lch[i] = 8'(8'h30 + i); lfe[i] = 0; lpe[i] = 0; end
    mdm_line = 4'd1; mdm_dcd = 1;
    push_set(8'hFF, 1);
    drain("R5 priority order");

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      int nr;
      for (int i = 0; i < 8; i++) begin
        lch[i] = 8'($urandom); lfe[i] = ($urandom % 5) == 0; lpe[i] = ($urandom % 5) == 0;
      end
      mdm_line = 4'($urandom % 8); mdm_dcd = 1'($urandom);
      push_set(8'($urandom), ($urandom % 3) == 0);
      nr = $urandom % 4;
      for (int k = 0; k < nr; k++) read_check("R5 random order");
    end
    drain("R5 random drain");

    // R6/R7 overflow
    for (int k = 0; k < 64; k++) push_one(k % 8, 8'($urandom), 0, 0);
    check(q.size() == 64, "R6 model full", q.size(), 64);
    push_one(2, 8'hEE, 0, 0);
    read_check("R6 head after drop");
    push_modem(4'd3, 1);
    push_one(4, 8'h77, 1, 1);
    drain("R6 R7 overrun marking");
    push_one(1, 8'h42, 1, 1);
    drain("R6 overrun cleared");

    // R10/R11 software master reset variants
    master_reset(0, 1);
    master_reset(1, 0);
    master_reset(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule